// File: doc/BRIEF.md
# Reorder Window with Gap Reservation

This block is a circular, in-order instruction window. Instructions normally take an entry at the tail. The front end can also ask for a contiguous hole of empty entries. This hole is called the gap, and it stands for instructions that will be fetched later. Once the gap is reserved, the tail jumps past it, and younger instructions keep arriving behind it. Program order in the window is therefore preserved even though the entries are written out of fetch order.

A separate fill port later writes the delayed instructions into the gap, from its first slot onward. The reserved length also covers any helper operations placed after the last delayed instruction. If the fill stream supplies fewer entries than reserved, a fill-done strobe pads the rest of the gap with no-ops. If it supplies more, an overflow flag tells the front end to squash. Retirement takes entries from the head and waits at any gap slot that is still empty. A squash input cuts the tail back to a given slot and closes the gap.

Top module: `reorder_gap_window`

## Requirements
- R1: After reset the window is empty: `full` is 0, `retire_valid` is 0, `alloc_ready` is 1 and `alloc_idx` is 0.
- R2: Each accepted allocation writes the entry at slot `alloc_idx` (the tail), and the tail then advances by one, modulo DEPTH. When DEPTH entries are occupied, `full` is 1 and `alloc_ready` is 0.
- R3: `gap_ready` is 1 only when all of the following hold: no gap is open, `squash_valid` is 0, and `gap_len` is between 1 and the number of free entries. On acceptance, `gap_base` equals the current tail, and the tail advances by `gap_len`. While `gap_req` is high, `alloc_ready` is 0.
- R4: Accepted fills are written into the gap in slot order, starting at the gap's base slot. `fill_idx` shows the slot the next fill takes.
- R5: Entries retire in slot order from the head. An entry retires when `retire_valid` and `retire_ready` are both 1. Retirement stops at a gap slot that is not yet filled.
- R6: A fill that arrives while a gap is open and all of its slots are already filled raises `gap_overflow` in that cycle, and its data is dropped.
- R7: `fill_done` while a gap is open raises `fill_complete` in that cycle and closes the gap. Every gap slot not yet filled becomes a no-op, which retires with `retire_nop` = 1.
- R8: Only one gap is open at a time. While a gap is open, `gap_ready` stays 0.
- R9: `squash_valid` keeps the entries from the head up to, but not including, slot `squash_tail`, or all entries if that run is longer than the occupancy. It closes any open gap and turns every kept unfilled slot into a no-op. In that cycle no allocation, reservation or retirement takes place.
- R10: `fill_valid` or `fill_done` while no gap is open has no effect and raises neither `gap_overflow` nor `fill_complete`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_data | input | DW | Payload of the allocated entry |
| alloc_ready | output | 1 | Allocation can be accepted this cycle |
| alloc_idx | output | IDX_W | Slot the allocation takes (current tail) |
| gap_req | input | 1 | Request to reserve a gap |
| gap_len | input | IDX_W+1 | Number of slots to reserve |
| gap_ready | output | 1 | Gap request accepted this cycle |
| gap_base | output | IDX_W | First slot of the gap being reserved |
| fill_valid | input | 1 | Write one delayed instruction into the gap |
| fill_data | input | DW | Payload of the fill |
| fill_done | input | 1 | End of the fill stream; pad the rest of the gap |
| fill_idx | output | IDX_W | Slot the next fill writes |
| gap_overflow | output | 1 | Fill arrived with no unfilled gap slot left |
| fill_complete | output | 1 | Gap closed by `fill_done` this cycle |
| retire_ready | input | 1 | Consumer takes the head entry |
| retire_valid | output | 1 | Head entry is present and filled |
| retire_data | output | DW | Payload of the head entry |
| retire_nop | output | 1 | Head entry is a padding no-op |
| retire_idx | output | IDX_W | Slot of the head entry |
| squash_valid | input | 1 | Cut the tail back |
| squash_tail | input | IDX_W | New tail slot on a squash |
| full | output | 1 | All DEPTH entries occupied |

## Verification
The main flow places a gap between an older and a younger allocation. The fills are then supplied in three ways: exactly the reserved count, fewer than reserved followed by fill-done, and one more than reserved. Comparing the retired payload order across these cases distinguishes a window that keeps program order from one that keeps fetch order, shows whether padding produces exactly the missing no-ops, and shows whether an extra fill leaks into the window. Separate cases put the head on an unfilled slot, ask for a second gap or a gap larger than the free space, and squash across a partially reserved gap. These show that stalls, refusals and the cut-back tail act at the right slot.

// File: rtl/rgw_pkg.sv
package rgw_pkg;

  // distance walking forward around the ring from 'origin' to 'slot'
  function automatic int unsigned ring_off(input int unsigned origin,
                                           input int unsigned slot,
                                           input int unsigned depth);
    return (slot + depth - origin) % depth;
  endfunction

  // true when 'slot' lies in the run of 'len' slots starting at 'start'
  function automatic logic in_run(input int unsigned slot,
                                  input int unsigned start,
                                  input int unsigned len,
                                  input int unsigned depth);
    return ring_off(start, slot, depth) < len;
  endfunction

  function automatic int unsigned min_u(input int unsigned a,
                                        input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/rgw_ptrs.sv
module rgw_ptrs #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             gap_fire,
  input  logic [CNT_W-1:0] gap_len,
  input  logic             retire_fire,
  input  logic             squash_valid,
  input  logic [IDX_W-1:0] squash_tail,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [CNT_W-1:0] occ,
  output logic [CNT_W-1:0] free_cnt
);
  import rgw_pkg::*;

  logic [IDX_W-1:0] head_q;
  logic [CNT_W-1:0] occ_q;
  logic [CNT_W-1:0] keep;
  logic [CNT_W-1:0] occ_grow;

  assign keep = CNT_W'(min_u(ring_off(32'(head_q), 32'(squash_tail), DEPTH),
                             32'(occ_q)));
  assign occ_grow = CNT_W'(alloc_fire) + (gap_fire ? gap_len : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      occ_q  <= '0;
    end else if (squash_valid) begin
      occ_q <= keep;
    end else begin
      head_q <= head_q + IDX_W'(retire_fire);
      occ_q  <= occ_q + occ_grow - CNT_W'(retire_fire);
    end
  end

  assign head_idx = head_q;
  assign tail_idx = head_q + occ_q[IDX_W-1:0];
  assign occ      = occ_q;
  assign free_cnt = CNT_W'(DEPTH) - occ_q;

  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CNT_W'(DEPTH));

  p_gap_moves_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_fire |=> tail_idx == IDX_W'($past(tail_idx) + $past(gap_len)));

  p_retire_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |=> head_idx == IDX_W'($past(head_idx) + 1'b1));

  p_squash_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (tail_idx == $past(squash_tail)) ||
                     (tail_idx == $past(tail_idx)));

endmodule

// File: rtl/rgw_gap.sv
module rgw_gap #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gap_fire,
  input  logic [IDX_W-1:0] base_idx,
  input  logic [CNT_W-1:0] gap_len,
  input  logic             fill_valid,
  input  logic             fill_done,
  input  logic             squash_valid,
  output logic             gap_open,
  output logic             fill_write,
  output logic [IDX_W-1:0] fill_idx,
  output logic             gap_overflow,
  output logic             fill_complete,
  output logic             pad_fire,
  output logic [IDX_W-1:0] pad_start,
  output logic [CNT_W-1:0] pad_len
);

  logic             open_q;
  logic [IDX_W-1:0] wr_q;
  logic [CNT_W-1:0] left_q;
  logic             room;

  assign room          = left_q != '0;
  assign fill_write    = open_q && fill_valid && room && !squash_valid;
  assign gap_overflow  = open_q && fill_valid && !room && !squash_valid;
  assign fill_complete = open_q && fill_done && !squash_valid;
  assign pad_fire      = fill_complete;
  assign pad_start     = wr_q + IDX_W'(fill_write);
  assign pad_len       = left_q - CNT_W'(fill_write);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      wr_q   <= '0;
      left_q <= '0;
    end else if (squash_valid) begin
      open_q <= 1'b0;
      left_q <= '0;
    end else if (gap_fire) begin
      open_q <= 1'b1;
      wr_q   <= base_idx;
      left_q <= gap_len;
    end else begin
      if (fill_write) begin
        wr_q   <= wr_q + 1'b1;
        left_q <= left_q - 1'b1;
      end
      if (fill_complete) open_q <= 1'b0;
    end
  end

  assign gap_open = open_q;
  assign fill_idx = wr_q;

  p_fill_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_write |=> wr_q == IDX_W'($past(wr_q) + 1'b1));

  p_overflow_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_overflow |=> (left_q == '0) && $stable(wr_q));

  p_complete_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_complete |=> !open_q);

  p_idle_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> !gap_overflow && !fill_complete && !fill_write);

endmodule

// File: rtl/rgw_store.sv
module rgw_store #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [DW-1:0]    alloc_data,
  input  logic             gap_fire,
  input  logic [IDX_W-1:0] gap_base,
  input  logic [CNT_W-1:0] gap_len,
  input  logic             fill_write,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [DW-1:0]    fill_data,
  input  logic             pad_fire,
  input  logic [IDX_W-1:0] pad_start,
  input  logic [CNT_W-1:0] pad_len,
  input  logic             squash_valid,
  input  logic [IDX_W-1:0] head_idx,
  output logic             head_filled,
  output logic             head_nop,
  output logic [DW-1:0]    head_data
);
  import rgw_pkg::*;

  logic          filled_q [DEPTH];
  logic          nop_q    [DEPTH];
  logic [DW-1:0] data_q   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic in_gap;
    logic in_pad;
    assign in_gap = in_run(i, 32'(gap_base), 32'(gap_len), DEPTH);
    assign in_pad = in_run(i, 32'(pad_start), 32'(pad_len), DEPTH);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        filled_q[i] <= 1'b1;
        nop_q[i]    <= 1'b0;
        data_q[i]   <= '0;
      end else if (squash_valid) begin
        if (!filled_q[i]) begin
          filled_q[i] <= 1'b1;
          nop_q[i]    <= 1'b1;
        end
      end else if (gap_fire && in_gap) begin
        filled_q[i] <= 1'b0;
        nop_q[i]    <= 1'b0;
      end else if (alloc_fire && alloc_idx == IDX_W'(i)) begin
        filled_q[i] <= 1'b1;
        nop_q[i]    <= 1'b0;
        data_q[i]   <= alloc_data;
      end else if (fill_write && fill_idx == IDX_W'(i)) begin
        filled_q[i] <= 1'b1;
        nop_q[i]    <= 1'b0;
        data_q[i]   <= fill_data;
      end else if (pad_fire && in_pad) begin
        filled_q[i] <= 1'b1;
        nop_q[i]    <= 1'b1;
      end
    end
  end

  assign head_filled = filled_q[head_idx];
  assign head_nop    = nop_q[head_idx];
  assign head_data   = data_q[head_idx];

  p_gap_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_fire |=> !filled_q[$past(gap_base)]);

  p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_write |=> filled_q[$past(fill_idx)] && !nop_q[$past(fill_idx)]);

  p_pad_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_fire && pad_len != '0) |=> nop_q[$past(pad_start)]);

endmodule

// File: rtl/reorder_gap_window.sv
module reorder_gap_window #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [DW-1:0]    alloc_data,
  output logic             alloc_ready,
  output logic [IDX_W-1:0] alloc_idx,
  input  logic             gap_req,
  input  logic [CNT_W-1:0] gap_len,
  output logic             gap_ready,
  output logic [IDX_W-1:0] gap_base,
  input  logic             fill_valid,
  input  logic [DW-1:0]    fill_data,
  input  logic             fill_done,
  output logic [IDX_W-1:0] fill_idx,
  output logic             gap_overflow,
  output logic             fill_complete,
  input  logic             retire_ready,
  output logic             retire_valid,
  output logic [DW-1:0]    retire_data,
  output logic             retire_nop,
  output logic [IDX_W-1:0] retire_idx,
  input  logic             squash_valid,
  input  logic [IDX_W-1:0] squash_tail,
  output logic             full
);

  logic             alloc_fire, gap_fire, retire_fire;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic [CNT_W-1:0] occ, free_cnt;
  logic             gap_open, fill_write, pad_fire;
  logic [IDX_W-1:0] pad_start;
  logic [CNT_W-1:0] pad_len;
  logic             head_filled;

  assign full        = occ == CNT_W'(DEPTH);
  assign alloc_ready = !full && !gap_req && !squash_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign gap_ready   = !gap_open && !squash_valid && gap_len != '0 &&
                       gap_len <= free_cnt;
  assign gap_fire    = gap_req && gap_ready;
  assign retire_valid = occ != '0 && head_filled && !squash_valid;
  assign retire_fire  = retire_valid && retire_ready;
  assign alloc_idx   = tail_idx;
  assign gap_base    = tail_idx;
  assign retire_idx  = head_idx;

  rgw_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .gap_fire(gap_fire),
    .gap_len(gap_len), .retire_fire(retire_fire), .squash_valid(squash_valid),
    .squash_tail(squash_tail), .head_idx(head_idx), .tail_idx(tail_idx),
    .occ(occ), .free_cnt(free_cnt)
  );

  rgw_gap #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .gap_fire(gap_fire), .base_idx(tail_idx),
    .gap_len(gap_len), .fill_valid(fill_valid), .fill_done(fill_done),
    .squash_valid(squash_valid), .gap_open(gap_open), .fill_write(fill_write),
    .fill_idx(fill_idx), .gap_overflow(gap_overflow),
    .fill_complete(fill_complete), .pad_fire(pad_fire),
    .pad_start(pad_start), .pad_len(pad_len)
  );

  rgw_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .alloc_idx(tail_idx),
    .alloc_data(alloc_data), .gap_fire(gap_fire), .gap_base(tail_idx),
    .gap_len(gap_len), .fill_write(fill_write), .fill_idx(fill_idx),
    .fill_data(fill_data), .pad_fire(pad_fire), .pad_start(pad_start),
    .pad_len(pad_len), .squash_valid(squash_valid), .head_idx(head_idx),
    .head_filled(head_filled), .head_nop(retire_nop), .head_data(retire_data)
  );

  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ready);

  p_one_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_fire |=> !gap_ready);

  p_squash_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> $stable(head_idx));

endmodule

// File: tb/sim_reorder_gap_window.sv
module sim_reorder_gap_window;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, gap_req = 1'b0, fill_valid = 1'b0, fill_done = 1'b0;
  logic retire_ready = 1'b0, squash_valid = 1'b0;
  logic [DW-1:0] alloc_data = '0, fill_data = '0;
  logic [4:0] gap_len = '0;
  logic [3:0] squash_tail = '0;
  logic alloc_ready, gap_ready, gap_overflow, fill_complete, retire_valid;
  logic retire_nop, full;
  logic [3:0] alloc_idx, gap_base, fill_idx, retire_idx;
  logic [DW-1:0] retire_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reorder_gap_window #(.DEPTH(DEPTH), .DW(DW)) u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    alloc_valid = 0; gap_req = 0; fill_valid = 0; fill_done = 0;
    retire_ready = 0; squash_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic alloc_one(input int d, input int exp_idx, input string tag);
    @(negedge clk); alloc_valid = 1; alloc_data = DW'(d); #1;
    chk({tag, " alloc_ready"}, int'(alloc_ready), 1);
    chk({tag, " alloc_idx"}, int'(alloc_idx), exp_idx);
    @(posedge clk); #1 alloc_valid = 0;
  endtask

  task automatic gap_try(input int len, input int exp_rdy, input int exp_base,
                         input string tag);
    @(negedge clk); gap_req = 1; gap_len = 5'(len); #1;
    chk({tag, " gap_ready"}, int'(gap_ready), exp_rdy);
    chk("R3 alloc_ready low during gap_req", int'(alloc_ready), 0);
    if (exp_rdy == 1) chk({tag, " gap_base"}, int'(gap_base), exp_base);
    @(posedge clk); #1 gap_req = 0;
  endtask

  task automatic fill_one(input int d, input int exp_ovf, input int exp_idx,
                          input string tag);
    @(negedge clk); fill_valid = 1; fill_data = DW'(d); #1;
    chk({tag, " gap_overflow"}, int'(gap_overflow), exp_ovf);
    if (exp_ovf == 0) chk({tag, " fill_idx"}, int'(fill_idx), exp_idx);
    @(posedge clk); #1 fill_valid = 0;
  endtask

  task automatic done_one(input int exp_cmp, input string tag);
    @(negedge clk); fill_done = 1; #1;
    chk({tag, " fill_complete"}, int'(fill_complete), exp_cmp);
    @(posedge clk); #1 fill_done = 0;
  endtask

  task automatic retire_one(input int d, input int nop, input string tag);
    @(negedge clk); #1;
    chk({tag, " retire_valid"}, int'(retire_valid), 1);
    chk({tag, " retire_nop"}, int'(retire_nop), nop);
    if (nop == 0) chk({tag, " retire_data"}, int'(retire_data), d);
    retire_ready = 1;
    @(posedge clk); #1 retire_ready = 0;
  endtask

  task automatic no_retire(input string tag);
    @(negedge clk); #1;
    chk({tag, " retire_valid"}, int'(retire_valid), 0);
  endtask

  // R1, R2, R5: plain allocate and retire
  task automatic t_plain();
    do_reset();
    @(negedge clk); #1;
    chk("R1 full", int'(full), 0);
    chk("R1 retire_valid", int'(retire_valid), 0);
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    chk("R1 alloc_idx", int'(alloc_idx), 0);
    alloc_one(10, 0, "R2 a0");
    alloc_one(11, 1, "R2 a1");
    alloc_one(12, 2, "R2 a2");
    retire_one(10, 0, "R5 r0");
    retire_one(11, 0, "R5 r1");
    retire_one(12, 0, "R5 r2");
    no_retire("R5 empty");
  endtask

  // R3..R7, R10: gap in the middle, exact fill plus one extra
  task automatic t_gap_exact();
    do_reset();
    alloc_one(20, 0, "R2 old");
    gap_try(3, 1, 1, "R3 gap");
    alloc_one(30, 4, "R3 after gap");
    alloc_one(31, 5, "R3 after gap2");
    retire_one(20, 0, "R5 old");
    no_retire("R5 stall at unfilled");
    fill_one(40, 0, 1, "R4 f0");
    fill_one(41, 0, 2, "R4 f1");
    fill_one(42, 0, 3, "R4 f2");
    fill_one(43, 1, 0, "R6 extra");
    done_one(1, "R7 close");
    done_one(0, "R10 done when closed");
    retire_one(40, 0, "R4 order0");
    retire_one(41, 0, "R4 order1");
    retire_one(42, 0, "R4 order2");
    retire_one(30, 0, "R6 no leak");
    retire_one(31, 0, "R5 young");
    no_retire("R6 empty");
  endtask

  // R7, R10: short fill padded with no-ops
  task automatic t_gap_short();
    do_reset();
    gap_try(4, 1, 0, "R3 gap4");
    alloc_one(50, 4, "R3 young");
    fill_one(60, 0, 0, "R4 only");
    done_one(1, "R7 pad");
    fill_one(61, 0, 1, "R10 fill closed");
    retire_one(60, 0, "R7 r0");
    retire_one(0, 1, "R7 nop1");
    retire_one(0, 1, "R7 nop2");
    retire_one(0, 1, "R7 nop3");
    retire_one(50, 0, "R7 young");
    no_retire("R10 fill ignored");
  endtask

  // R8, R3: second gap, size limits, full window
  task automatic t_limits();
    do_reset();
    gap_try(2, 1, 0, "R8 first");
    gap_try(1, 0, 0, "R8 second held");
    do_reset();
    for (int i = 0; i < 14; i++) alloc_one(i, i, "R2 fill");
    gap_try(0, 0, 0, "R3 len0");
    gap_try(3, 0, 0, "R3 too big");
    gap_try(2, 1, 14, "R3 fits");
    @(negedge clk); #1;
    chk("R2 full", int'(full), 1);
    chk("R2 alloc_ready full", int'(alloc_ready), 0);
  endtask

  // R9: squash across a reserved gap
  task automatic t_squash();
    do_reset();
    alloc_one(1, 0, "R9 a0");
    alloc_one(2, 1, "R9 a1");
    gap_try(3, 1, 2, "R9 gap");
    alloc_one(7, 5, "R9 y0");
    @(negedge clk); squash_valid = 1; squash_tail = 4'd3; #1;
    chk("R9 alloc blocked", int'(alloc_ready), 0);
    chk("R9 retire blocked", int'(retire_valid), 0);
    @(posedge clk); #1 squash_valid = 0;
    @(negedge clk); #1;
    chk("R9 new tail", int'(alloc_idx), 3);
    fill_one(9, 0, 2, "R9 gap closed");
    retire_one(1, 0, "R9 k0");
    retire_one(2, 0, "R9 k1");
    retire_one(0, 1, "R9 nop");
    no_retire("R9 empty");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_plain();
    t_gap_exact();
    t_gap_short();
    t_limits();
    t_squash();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule